// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block is the register side of a real-time clock. Software reaches it through two byte-wide ports: one strobe loads an index (0 to 13) into an internal selector, and separate write and read strobes on the data port then move one byte to or from the selected location. Indices 0 to 9 hold seconds, alarm bytes, minutes, hours, weekday, day of month, month and year. Index 10 and 11 are the two status registers that control the time base and the operating mode. Index 12 and 13 are placeholder status registers that always read as zero.

At reset the time and date bytes take their values from parameters. Month and weekday are stored one-based, with weekday 1 meaning Sunday. A parameter can switch the year byte to a two-digit BCD form. The block also drives a periodic interrupt. While the enable bit in the mode register is set, an internal timer fires every `TICK_CYCLES` clock cycles and raises a one-cycle pulse on `irq`. Any access the block does not support is refused and sets a sticky `err` output, which only a reset clears.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with `wdata` in 0..13 selects that location. An index write with `wdata` above 13 leaves the selector unchanged and sets `err`.
- R2: A data read returns the selected byte on `rdata` one clock after the `data_re` edge, and `rdata` holds that value until the next read. For indices 0..9, the byte returned is the last value written there.
- R3: After reset the data bytes hold these values: index 0 seconds, index 2 minutes, index 4 hours, index 6 weekday (zero-based parameter plus 1), index 7 day of month, index 8 month (zero-based parameter plus 1), index 9 year (years since 1900). Indices 1, 3 and 5 hold 0.
- R4: With `YEAR_BCD`=1, index 9 resets to the year modulo 100 in two BCD digits, with the tens digit in bits 7:4 and the ones digit in bits 3:0.
- R5: Status A (index 10) resets to 0x26. A write of exactly 0x26 is stored. Any other write value is refused, leaves status A unchanged, and sets `err`.
- R6: Each read of status A first inverts bit 7 (update in progress) and then returns the new value, so the first read after reset returns 0xA6 and the next returns 0x26.
- R7: Status B (index 11) resets to 0x46. Its bits are: bit 6 periodic enable, bit 3 square-wave enable, bit 2 binary mode, bit 1 24-hour mode. A write is accepted only if all bits other than 6 and 3 equal 0x06. A refused write leaves status B unchanged and sets `err`.
- R8: While bit 6 of status B is set, `irq` pulses high for exactly one cycle every `TICK_CYCLES` cycles. The timer runs from reset, and the first pulse comes `TICK_CYCLES` edges after reset is released.
- R9: If an accepted write turns bit 6 of status B on from off, the first pulse comes `TICK_CYCLES` edges after the write edge. Writing bit 6 as 1 while it is already 1 does not change the timer's phase. Clearing bit 6 cancels the pending tick, and no pulse occurs while the bit stays cleared.
- R10: Indices 12 and 13 read as 0x00. Writes to them are refused and set `err`.
- R11: `err` is 0 after reset. Once set, it stays set through any later traffic until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Load `wdata` as the register index |
| data_we | input | 1 | Write `wdata` to the selected register |
| data_re | input | 1 | Read the selected register into `rdata` |
| wdata | input | 8 | Index or data byte |
| rdata | output | 8 | Last read result |
| irq | output | 1 | One-cycle periodic interrupt pulse |
| err | output | 1 | Sticky flag for a refused access |

## Verification
The bench targets these corner cases:
- Back-to-back reads of status A. A design that toggled after the read, or not at all, would return 0x26 first instead of 0xA6.
- A refused index write followed by a data read with no new index. A design that loaded the bad index would return the wrong byte.
- Rewriting the periodic enable in the middle of a period. The next pulse must arrive on the old schedule (one cycle sooner than a restart), so a design that restarted its timer would show up.
- Disable and re-enable of the periodic tick. A stale pulse while disabled, or a wrong delay after re-enabling, would be caught.
- Every refused write is checked one at a time, with a reset between them. A design that stored rejected data, or failed to set the sticky flag, would be seen at the ports.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] IDX_STAT_A = 8'h0A;
  localparam logic [7:0] IDX_STAT_B = 8'h0B;
  localparam logic [7:0] IDX_STAT_C = 8'h0C;
  localparam logic [7:0] IDX_STAT_D = 8'h0D;
  localparam logic [7:0] IDX_MAX    = 8'h0D;
  localparam int         NUM_DATA   = 10;

  localparam logic [7:0] A_UIP     = 8'h80;
  localparam logic [7:0] A_DEFAULT = 8'h26;

  localparam logic [7:0] B_PIE     = 8'h40;
  localparam logic [7:0] B_SQWE    = 8'h08;
  localparam logic [7:0] B_BIN     = 8'h04;
  localparam logic [7:0] B_24H     = 8'h02;
  localparam logic [7:0] B_FREE    = B_PIE | B_SQWE;
  localparam logic [7:0] B_MUST    = B_BIN | B_24H;
  localparam logic [7:0] B_DEFAULT = B_PIE | B_BIN | B_24H;

  typedef enum logic [1:0] {
    SEL_DATA,
    SEL_A,
    SEL_B,
    SEL_ZERO
  } rd_sel_e;

  // Two BCD digits of (y mod 100), tens digit in the upper nibble.
  function automatic logic [7:0] year_to_bcd(int unsigned y);
    int unsigned r;
    r = y % 100;
    return {4'((r / 10) % 10), 4'(r % 10)};
  endfunction

  function automatic logic b_write_ok(logic [7:0] v);
    return (v & ~B_FREE) == B_MUST;
  endfunction

  function automatic rd_sel_e read_select(logic [7:0] idx);
    if (idx == IDX_STAT_A)      return SEL_A;
    else if (idx == IDX_STAT_B) return SEL_B;
    else if (idx >= IDX_STAT_C) return SEL_ZERO;
    else                        return SEL_DATA;
  endfunction

  function automatic logic [7:0] clock_reset_byte(
    int unsigned i, int unsigned sec, int unsigned mins, int unsigned hour,
    int unsigned wday0, int unsigned mday, int unsigned mon0,
    int unsigned year, bit bcd);
    case (i)
      0:       return 8'(sec);
      2:       return 8'(mins);
      4:       return 8'(hour);
      6:       return 8'(wday0 + 1);
      7:       return 8'(mday);
      8:       return 8'(mon0 + 1);
      9:       return bcd ? year_to_bcd(year) : 8'(year);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_we,
  input  logic [7:0] wdata,
  output logic [7:0] idx,
  output logic       bad_addr
);

  assign bad_addr = addr_we && (wdata > IDX_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idx <= 8'h00;
    else if (addr_we && !bad_addr) idx <= wdata;
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |=> $stable(idx)); // R1

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> (idx <= IDX_MAX)); // R1

endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_a,
  input  logic       wr_b,
  input  logic       rd_a,
  input  logic [7:0] wdata,
  output logic [7:0] stat_a,
  output logic [7:0] stat_b,
  output logic       bad_a,
  output logic       bad_b,
  output logic       tick_en
);

  logic a_ok;
  logic b_ok;

  assign a_ok    = (wdata == A_DEFAULT);
  assign b_ok    = b_write_ok(wdata);
  assign bad_a   = wr_a && !a_ok;
  assign bad_b   = wr_b && !b_ok;
  assign tick_en = (stat_b & B_PIE) != 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stat_a <= A_DEFAULT;
    else if (wr_a && a_ok)   stat_a <= wdata;
    else if (rd_a && !wr_a)  stat_a <= stat_a ^ A_UIP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            stat_b <= B_DEFAULT;
    else if (wr_b && b_ok) stat_b <= wdata;
  end

  AST_UIP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a && !wr_a) |=> (stat_a[7] != $past(stat_a[7]))); // R6

  AST_A_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_a && !rd_a) |=> $stable(stat_a)); // R5

  AST_B_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    bad_b |=> $stable(stat_b)); // R7

  AST_B_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b |=> ((stat_b & ~B_FREE) == B_MUST)); // R7

endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int unsigned TICK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic irq
);

  localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          fire;

  assign fire = enable && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (!enable) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (fire) begin
      cnt <= '0;
      irq <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      irq <= 1'b0;
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq); // R9

  generate
    if (TICK_CYCLES > 1) begin : g_pulse_chk
      AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    end
  endgenerate

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 50000,
  parameter int unsigned INIT_SEC    = 0,
  parameter int unsigned INIT_MIN    = 0,
  parameter int unsigned INIT_HOUR   = 0,
  parameter int unsigned INIT_WDAY0  = 0,
  parameter int unsigned INIT_MDAY   = 1,
  parameter int unsigned INIT_MON0   = 0,
  parameter int unsigned INIT_YEAR   = 100,
  parameter bit          YEAR_BCD    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic       data_re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       err
);

  logic [7:0] idx;
  logic       bad_addr;
  logic       bad_a;
  logic       bad_b;
  logic       bad_cd;
  logic       wr_a;
  logic       wr_b;
  logic       rd_a;
  logic       tick_en;
  logic [7:0] stat_a;
  logic [7:0] stat_b;
  logic [7:0] data_q [NUM_DATA];
  logic [7:0] data_sel;
  rd_sel_e    sel;

  rtc_index_latch u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_we  (addr_we),
    .wdata    (wdata),
    .idx      (idx),
    .bad_addr (bad_addr)
  );

  assign sel    = read_select(idx);
  assign wr_a   = data_we && (sel == SEL_A);
  assign wr_b   = data_we && (sel == SEL_B);
  assign rd_a   = data_re && (sel == SEL_A);
  assign bad_cd = data_we && (sel == SEL_ZERO);

  rtc_status_regs u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .rd_a    (rd_a),
    .wdata   (wdata),
    .stat_a  (stat_a),
    .stat_b  (stat_b),
    .bad_a   (bad_a),
    .bad_b   (bad_b),
    .tick_en (tick_en)
  );

  rtc_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (tick_en),
    .irq    (irq)
  );

  generate
    for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_byte
      localparam logic [7:0] RST_VAL = clock_reset_byte(gi, INIT_SEC, INIT_MIN,
        INIT_HOUR, INIT_WDAY0, INIT_MDAY, INIT_MON0, INIT_YEAR, YEAR_BCD);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   data_q[gi] <= RST_VAL;
        else if (data_we && (idx == 8'(gi)))          data_q[gi] <= wdata;
      end
    end
  endgenerate

  always_comb begin
    data_sel = 8'h00;
    for (int k = 0; k < NUM_DATA; k++)
      if (idx == 8'(k)) data_sel = data_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= 8'h00;
    else if (data_re) begin
      case (sel)
        SEL_A:    rdata <= stat_a ^ A_UIP;
        SEL_B:    rdata <= stat_b;
        SEL_ZERO: rdata <= 8'h00;
        default:  rdata <= data_sel;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err | bad_addr | bad_a | bad_b | bad_cd;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R11

  AST_ERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_addr || bad_cd) |=> err); // R10

  AST_CD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_re && (idx >= IDX_STAT_C)) |=> (rdata == 8'h00)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_re |=> $stable(rdata)); // R2

endmodule

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb_top;

  localparam int unsigned TICK = 16;
  localparam int unsigned P_SEC = 30, P_MIN = 45, P_HOUR = 13, P_WDAY0 = 3;
  localparam int unsigned P_MDAY = 15, P_MON0 = 6, P_YEAR = 124;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rdata_bcd;
  logic       irq, err, irq_bcd, err_bcd;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [10];

  always #10 clk = ~clk;

  rtc_regfile #(.TICK_CYCLES(TICK), .INIT_SEC(P_SEC), .INIT_MIN(P_MIN),
    .INIT_HOUR(P_HOUR), .INIT_WDAY0(P_WDAY0), .INIT_MDAY(P_MDAY),
    .INIT_MON0(P_MON0), .INIT_YEAR(P_YEAR), .YEAR_BCD(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we),
    .data_re(data_re), .wdata(wdata), .rdata(rdata), .irq(irq), .err(err));

  rtc_regfile #(.TICK_CYCLES(TICK), .INIT_SEC(P_SEC), .INIT_MIN(P_MIN),
    .INIT_HOUR(P_HOUR), .INIT_WDAY0(P_WDAY0), .INIT_MDAY(P_MDAY),
    .INIT_MON0(P_MON0), .INIT_YEAR(P_YEAR), .YEAR_BCD(1'b1)) dut_bcd_i (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .data_we(data_we),
    .data_re(data_re), .wdata(wdata), .rdata(rdata_bcd), .irq(irq_bcd),
    .err(err_bcd));

  function automatic logic [7:0] exp_reset(int i, bit bcd);
    int y;
    y = P_YEAR % 100;
    if (i == 0) return 8'(P_SEC);
    if (i == 2) return 8'(P_MIN);
    if (i == 4) return 8'(P_HOUR);
    if (i == 6) return 8'(P_WDAY0 + 1);
    if (i == 7) return 8'(P_MDAY);
    if (i == 8) return 8'(P_MON0 + 1);
    if (i == 9) return bcd ? 8'((y / 10) * 16 + (y % 10)) : 8'(P_YEAR);
    return 8'h00;
  endfunction

  function automatic bit b_accept(logic [7:0] v);
    return (v[7] == 1'b0) && (v[5:4] == 2'b00) && (v[2:0] == 3'b110);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(logic [7:0] v);
    @(negedge clk); addr_we = 1'b1; wdata = v;
    @(posedge clk); #1 addr_we = 1'b0;
  endtask

  task automatic put(logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(posedge clk); #1 data_we = 1'b0;
  endtask

  task automatic get(output logic [7:0] v);
    @(negedge clk); data_re = 1'b1;
    @(posedge clk); #1 data_re = 1'b0;
    v = rdata;
  endtask

  task automatic wr_reg(logic [7:0] i, logic [7:0] v);
    set_idx(i); put(v);
  endtask

  task automatic rd_reg(logic [7:0] i, output logic [7:0] v);
    set_idx(i); get(v);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1 n++;
    end while (!irq && n < 4 * TICK);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 10; i++) model[i] = exp_reset(i, 1'b0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int n;
    void'($urandom(32'h0000_5EED));
    for (int i = 0; i < 10; i++) model[i] = exp_reset(i, 1'b0);
    #5;
    chk("R11 err low in reset", err, 0);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;

    // R8: first pulse TICK edges after reset release, then periodic
    wait_irq(n);
    chk("R8 first pulse delay", n, TICK);
    @(posedge clk); #1 chk("R8 pulse one cycle", irq, 0);
    wait_irq(n);
    chk("R8 period", n, TICK - 1);

    // R3 / R4 reset bytes in both variants
    for (int i = 0; i < 10; i++) begin
      set_idx(8'(i)); get(v);
      chk($sformatf("R3 reset byte %0d", i), v, exp_reset(i, 1'b0));
      if (i == 9) chk("R4 bcd year", rdata_bcd, exp_reset(9, 1'b1));
    end

    // R6 status A alternation, R5 default
    rd_reg(8'h0A, v); chk("R6 first A read", v, 8'hA6);
    get(v);            chk("R6 second A read", v, 8'h26);
    get(v);            chk("R6 third A read", v, 8'hA6);
    put(8'h26);        get(v); chk("R5 A write 0x26 accepted", v, 8'hA6);
    rd_reg(8'h0B, v); chk("R7 B reset", v, 8'h46);
    rd_reg(8'h0C, v); chk("R10 C reads zero", v, 8'h00);
    rd_reg(8'h0D, v); chk("R10 D reads zero", v, 8'h00);

    // R2 random traffic over data bytes
    for (int it = 0; it < 200; it++) begin
      int i;
      i = int'($urandom_range(9, 0));
      if ($urandom_range(1, 0) == 1) begin
        v = 8'($urandom());
        wr_reg(8'(i), v);
        model[i] = v;
      end else begin
        rd_reg(8'(i), v);
        chk($sformatf("R2 readback idx %0d", i), v, model[i]);
      end
    end
    chk("R11 no error after legal traffic", err, 0);

    // R9 phase kept on rewrite of enable
    set_idx(8'h0B);
    wait_irq(n);
    put(8'h46);
    wait_irq(n);
    chk("R9 rewrite keeps phase", n, TICK - 1);

    // R9 disable cancels, re-enable restarts
    put(8'h06);
    n = 0;
    for (int c = 0; c < 3 * TICK; c++) begin
      @(posedge clk); #1 if (irq) n++;
    end
    chk("R9 no pulse while disabled", n, 0);
    put(8'h4E);
    wait_irq(n);
    chk("R9 re-enable delay", n, TICK);
    get(v); chk("R7 B accepts SQWE+PIE", v, 8'h4E);
    chk("R7 b_accept model", b_accept(8'h4E), 1);
    chk("R11 still clean", err, 0);

    // R1 bad index ignored
    wr_reg(8'h05, 8'h3C);
    set_idx(8'h0E);
    chk("R1 bad index flags err", err, 1);
    get(v); chk("R1 index unchanged", v, 8'h3C);
    wr_reg(8'h02, 8'h11);
    chk("R11 err sticky", err, 1);
    do_reset();
    chk("R11 reset clears err", err, 0);

    // R5 bad A write
    wr_reg(8'h0A, 8'h27);
    chk("R5 bad A flags err", err, 1);
    get(v); chk("R5 A unchanged", v, 8'hA6);
    do_reset();

    // R7 bad B writes
    wr_reg(8'h0B, 8'h47);
    chk("R7 bad B flags err", err, 1);
    get(v); chk("R7 B unchanged", v, 8'h46);
    do_reset();
    wr_reg(8'h0B, 8'h42);
    chk("R7 binary cleared refused", err, 1);
    get(v); chk("R7 B unchanged after 0x42", v, 8'h46);
    do_reset();

    // R10 C/D writes
    wr_reg(8'h0C, 8'h55);
    chk("R10 C write flags err", err, 1);
    get(v); chk("R10 C still zero", v, 8'h00);
    do_reset();
    wr_reg(8'h0D, 8'hFF);
    chk("R10 D write flags err", err, 1);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule